// File: doc/BRIEF.md
# Signature-Checked Commit Arbiter

This block decides which cores may commit their hardware transactions. Each core holds its request high and presents two fixed-width Bloom-style signatures: one summarising the lines it read and one summarising the lines it wrote. A core that receives a grant keeps it until it pulses its commit-done input. The grant drops on the next clock edge, and that core's captured signatures stop taking part in conflict checks from the same edge.

Two modes are available. In serial mode only one committer may be active at a time. In parallel mode several committers may be active together, but only when none of their signatures can overlap in a way that would break atomicity. A new committer is refused if its write signature meets any active committer's read or write signature, or if its read signature meets any active committer's write signature. Two read signatures may overlap freely. Pending requests are served in round-robin order, and at most one new grant is issued per cycle.

Top module: `commit_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every grant bit is 0.
- R2: A grant bit rises only for a core whose request was 1 at the preceding edge, and at most one grant bit rises per cycle.
- R3: A grant bit that is 1 stays 1 until its core drives done to 1 at an edge; it is 0 after that edge.
- R4: When parallel_en is 0, a new grant is issued only at an edge where no grant bit is 1.
- R5: When parallel_en is 1, a requester is refused while any granted core has captured signatures for which (requester write AND (active read OR active write)) or (requester read AND active write) is nonzero.
- R6: When parallel_en is 1, a requester whose signatures clear every active committer is granted while the others stay granted, including when only read signatures overlap.
- R7: Eligible requesters are scanned in increasing core index, wrapping around, starting one past the most recently granted core; after reset the scan starts at core 0.
- R8: Conflict checks use the signatures a core presented in the cycle of its grant; later changes on that core's signature inputs have no effect.
- R9: A done pulse from a core that holds no grant has no effect on any grant bit.
- R10: A core whose request is 0 is never newly granted, even when it would win the scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| parallel_en | input | 1 | 1 = parallel commits allowed, 0 = serial |
| req | input | N_CORE | Per-core commit request, held until granted |
| rd_sig | input | N_CORE*SIG_W | Read signatures, core i in bits [i*SIG_W +: SIG_W] |
| wr_sig | input | N_CORE*SIG_W | Write signatures, same packing |
| done | input | N_CORE | Per-core commit-done pulse |
| grant | output | N_CORE | Per-core commit permission, held until done |

## Verification
The directed serial sequence gives two cores disjoint signatures. Only a refused second grant can then tell serial gating apart from conflict gating. The parallel sequence presents three overlap kinds against active committers: read over write, write over read, and write over write. Each must be refused, and a read-over-read overlap must still be granted, which separates the asymmetric conflict rule from a plain any-bit overlap. Changing a granted core's signature inputs and pulsing done from an idle core shows that captured state, not live inputs, governs the checks. Long random runs use sparse signatures and random mode switches, comparing every cycle against a bench model so that rotation order and release timing are covered across many mixes.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   typedef enum logic [0:0] {
      ARB_SERIAL   = 1'b0,
      ARB_PARALLEL = 1'b1
   } arb_mode_e;

   localparam int unsigned CMT_MAX_CORES = 64;
   localparam int unsigned CMT_MAX_SIG_W = 1024;

endpackage

// File: rtl/cmt_slot.sv
module cmt_slot #(
   parameter int unsigned SIG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             done,
   input  logic [SIG_W-1:0] rd_in,
   input  logic [SIG_W-1:0] wr_in,
   output logic             active,
   output logic [SIG_W-1:0] rd_q,
   output logic [SIG_W-1:0] wr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         rd_q   <= '0;
         wr_q   <= '0;
      end else if (take) begin
         active <= 1'b1;
         rd_q   <= rd_in;
         wr_q   <= wr_in;
      end else if (done) begin
         active <= 1'b0;
      end
   end

endmodule

// File: rtl/cmt_conflict.sv
module cmt_conflict #(
   parameter int unsigned N_CORE = 4,
   parameter int unsigned SIG_W  = 16
) (
   input  logic [SIG_W-1:0]        cand_rd,
   input  logic [SIG_W-1:0]        cand_wr,
   input  logic [N_CORE-1:0]       act,
   input  logic [N_CORE*SIG_W-1:0] act_rd_flat,
   input  logic [N_CORE*SIG_W-1:0] act_wr_flat,
   output logic                    blocked
);

   logic [N_CORE-1:0] hit;

   for (genvar j = 0; j < N_CORE; j++) begin : g_vs
      logic [SIG_W-1:0] a_rd;
      logic [SIG_W-1:0] a_wr;
      logic             wr_meets;
      logic             rd_meets;
      assign a_rd     = act_rd_flat[j*SIG_W +: SIG_W];
      assign a_wr     = act_wr_flat[j*SIG_W +: SIG_W];
      assign wr_meets = |(cand_wr & (a_rd | a_wr));
      assign rd_meets = |(cand_rd & a_wr);
      assign hit[j]   = act[j] & (wr_meets | rd_meets);
   end

   assign blocked = |hit;

endmodule

// File: rtl/cmt_rr_pick.sv
module cmt_rr_pick #(
   parameter int unsigned N_CORE = 4,
   localparam int unsigned IDX_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
   input  logic [N_CORE-1:0] elig,
   input  logic [IDX_W-1:0]  last,
   output logic [N_CORE-1:0] pick,
   output logic [IDX_W-1:0]  pick_idx,
   output logic              found
);

   always_comb begin
      pick     = '0;
      pick_idx = last;
      found    = 1'b0;
      for (int k = 1; k <= int'(N_CORE); k++) begin
         int c;
         c = (int'(last) + k) % int'(N_CORE);
         if (!found && elig[c]) begin
            pick[c]  = 1'b1;
            pick_idx = IDX_W'(c);
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/commit_arbiter.sv
module commit_arbiter #(
   parameter int unsigned N_CORE         = 4,
   parameter int unsigned SIG_W          = 16,
   parameter bit          ALLOW_PARALLEL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    parallel_en,
   input  logic [N_CORE-1:0]       req,
   input  logic [N_CORE*SIG_W-1:0] rd_sig,
   input  logic [N_CORE*SIG_W-1:0] wr_sig,
   input  logic [N_CORE-1:0]       done,
   output logic [N_CORE-1:0]       grant
);
   import cmt_pkg::*;

   localparam int unsigned IDX_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;
   localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N_CORE - 1);

   if (N_CORE < 2 || N_CORE > CMT_MAX_CORES) begin : g_bad_cores
      $error("commit_arbiter: N_CORE out of range");
   end
   if (SIG_W < 1 || SIG_W > CMT_MAX_SIG_W) begin : g_bad_sig
      $error("commit_arbiter: SIG_W out of range");
   end

   logic [N_CORE-1:0]       act_q;
   logic [N_CORE*SIG_W-1:0] act_rd_flat;
   logic [N_CORE*SIG_W-1:0] act_wr_flat;
   logic [N_CORE-1:0]       blocked;
   logic [N_CORE-1:0]       elig;
   logic [N_CORE-1:0]       take;
   logic [IDX_W-1:0]        take_idx;
   logic                    take_any;
   logic [IDX_W-1:0]        last_q;
   arb_mode_e               mode;

   // committer slots
   for (genvar i = 0; i < N_CORE; i++) begin : g_slot
      cmt_slot #(.SIG_W(SIG_W)) i_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .take   (take[i]),
         .done   (done[i]),
         .rd_in  (rd_sig[i*SIG_W +: SIG_W]),
         .wr_in  (wr_sig[i*SIG_W +: SIG_W]),
         .active (act_q[i]),
         .rd_q   (act_rd_flat[i*SIG_W +: SIG_W]),
         .wr_q   (act_wr_flat[i*SIG_W +: SIG_W])
      );
   end

   // mode selection and conflict screening
   if (ALLOW_PARALLEL) begin : g_par
      assign mode = parallel_en ? ARB_PARALLEL : ARB_SERIAL;
      for (genvar i = 0; i < N_CORE; i++) begin : g_chk
         cmt_conflict #(.N_CORE(N_CORE), .SIG_W(SIG_W)) i_conflict (
            .cand_rd     (rd_sig[i*SIG_W +: SIG_W]),
            .cand_wr     (wr_sig[i*SIG_W +: SIG_W]),
            .act         (act_q),
            .act_rd_flat (act_rd_flat),
            .act_wr_flat (act_wr_flat),
            .blocked     (blocked[i])
         );
      end
   end else begin : g_ser
      logic unused_mode;
      assign unused_mode = parallel_en;
      assign mode        = ARB_SERIAL;
      assign blocked     = '1;
   end

   always_comb begin
      if (mode == ARB_PARALLEL) begin
         elig = req & ~act_q & ~blocked;
      end else begin
         elig = req & ~act_q & {N_CORE{~|act_q}};
      end
   end

   cmt_rr_pick #(.N_CORE(N_CORE)) i_pick (
      .elig     (elig),
      .last     (last_q),
      .pick     (take),
      .pick_idx (take_idx),
      .found    (take_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= LAST_RST;
      end else if (take_any) begin
         last_q <= take_idx;
      end
   end

   assign grant = act_q;

endmodule

// File: rtl/cmt_arb_chk.sv
module cmt_arb_chk #(
   parameter int unsigned N_CORE = 4,
   parameter int unsigned SIG_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    parallel_en,
   input logic [N_CORE-1:0]       req,
   input logic [N_CORE-1:0]       done,
   input logic [N_CORE-1:0]       grant,
   input logic [N_CORE*SIG_W-1:0] act_rd_flat,
   input logic [N_CORE*SIG_W-1:0] act_wr_flat
);

   logic pair_clash;

   always_comb begin
      pair_clash = 1'b0;
      for (int i = 0; i < int'(N_CORE); i++) begin
         for (int j = 0; j < int'(N_CORE); j++) begin
            if (i != j && grant[i] && grant[j]) begin
               if (|(act_wr_flat[i*SIG_W +: SIG_W] &
                     (act_wr_flat[j*SIG_W +: SIG_W] | act_rd_flat[j*SIG_W +: SIG_W])))
                  pair_clash = 1'b1;
            end
         end
      end
   end

   AST_NEW_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~$past(grant) & ~$past(req)) == '0)); // R2

   AST_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(grant & ~$past(grant)) <= 1)); // R2

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(grant) & ~$past(done) & ~grant) == '0)); // R3

   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & $past(grant) & $past(done)) == '0)); // R3

   AST_SERIAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((!$past(parallel_en) && ((grant & ~$past(grant)) != '0)) |-> ($past(grant) == '0))); // R4

   AST_PAIR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!pair_clash)); // R5

endmodule

bind commit_arbiter cmt_arb_chk #(.N_CORE(N_CORE), .SIG_W(SIG_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .parallel_en (parallel_en),
   .req         (req),
   .done        (done),
   .grant       (grant),
   .act_rd_flat (act_rd_flat),
   .act_wr_flat (act_wr_flat)
);

// File: tb/test_commit_arbiter.sv
`timescale 1ns/1ps
module test_commit_arbiter;
   localparam int N = 4;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic par = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] done = '0;
   logic [W-1:0] rd [N];
   logic [W-1:0] wr [N];
   logic [N*W-1:0] rd_flat, wr_flat;
   logic [N-1:0] grant;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         rd_flat[i*W +: W] = rd[i];
         wr_flat[i*W +: W] = wr[i];
      end
   end

   commit_arbiter #(.N_CORE(N), .SIG_W(W)) i_commit_arbiter (
      .clk(clk), .rst_n(rst_n), .parallel_en(par), .req(req),
      .rd_sig(rd_flat), .wr_sig(wr_flat), .done(done), .grant(grant)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // bench model state
   logic [N-1:0] m_act;
   logic [W-1:0] m_rd [N];
   logic [W-1:0] m_wr [N];
   int m_last;

   function automatic bit clashes(int c);
      bit r = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (m_act[j] && (((wr[c] & (m_rd[j] | m_wr[j])) != '0) || ((rd[c] & m_wr[j]) != '0)))
            r = 1'b1;
      end
      return r;
   endfunction

   function automatic int model_pick();
      int p = -1;
      for (int k = 1; k <= N; k++) begin
         int c = (m_last + k) % N;
         if (p < 0 && req[c] && !m_act[c]) begin
            if (par ? !clashes(c) : (m_act == '0)) p = c;
         end
      end
      return p;
   endfunction

   task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s grant=%b expected=%b", tag, act, exp);
      end
   endtask

   // inputs already set after a falling edge; advance one cycle and compare
   task automatic cycle(string tag);
      logic [N-1:0] nxt;
      int p;
      nxt = m_act & ~done;
      p = model_pick();
      if (p >= 0) begin
         nxt[p] = 1'b1;
         m_rd[p] = rd[p];
         m_wr[p] = wr[p];
         m_last = p;
      end
      @(posedge clk);
      @(negedge clk);
      m_act = nxt;
      check(tag, grant, m_act);
   endtask

   task automatic set_sig(int c, logic [W-1:0] r, logic [W-1:0] w);
      rd[c] = r;
      wr[c] = w;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog grant=%b expected=finish", grant);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         rd[i] = '0; wr[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
      end
      m_act = '0;
      m_last = N - 1;
      repeat (3) @(negedge clk);
      check("R1 in reset", grant, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", grant, '0);

      // serial mode, disjoint signatures
      par = 1'b0;
      set_sig(1, 16'h0001, 16'h0002);
      set_sig(2, 16'h0004, 16'h0008);
      req = 4'b0110;
      cycle("R7 serial first");
      check("R7 core1 first after reset", grant, 4'b0010);
      cycle("R4 serial wait");
      check("R4 core2 held off", grant, 4'b0010);
      done[1] = 1'b1;
      cycle("R3 release");
      check("R3 grant cleared after done", grant, 4'b0000);
      done = '0; req[1] = 1'b0;
      cycle("R4 next serial");
      check("R4 core2 granted once idle", grant, 4'b0100);
      done[2] = 1'b1; req = '0;
      cycle("R3 release core2");
      done = '0;

      // parallel mode conflict rules
      par = 1'b1;
      set_sig(0, 16'h0001, 16'h0010);
      req = 4'b0001;
      cycle("R6 first parallel");
      check("R6 core0 granted", grant, 4'b0001);
      set_sig(1, 16'h0010, 16'h0100);
      req = 4'b0011;
      cycle("R5 read over write");
      check("R5 core1 refused rd/wr", grant, 4'b0001);
      set_sig(1, 16'h0001, 16'h0100);
      cycle("R6 read over read");
      check("R6 core1 granted rd/rd", grant, 4'b0011);
      set_sig(2, 16'h0000, 16'h0001);
      req = 4'b0111;
      cycle("R5 write over read");
      check("R5 core2 refused wr/rd", grant, 4'b0011);
      set_sig(3, 16'h0000, 16'h0100);
      req = 4'b1111;
      cycle("R5 write over write");
      check("R5 core3 refused wr/wr", grant, 4'b0011);
      set_sig(0, 16'h0000, 16'h0000);
      set_sig(1, 16'h0000, 16'h0000);
      req = 4'b0100;
      cycle("R8 captured sigs");
      check("R8 core2 still refused", grant, 4'b0011);
      req = 4'b0000;
      done[3] = 1'b1;
      cycle("R9 stray done");
      check("R9 stray done ignored", grant, 4'b0011);
      done = '0;
      done[0] = 1'b1;
      cycle("R3 release core0");
      check("R3 core0 released", grant, 4'b0010);
      done = '0;
      done[1] = 1'b1;
      cycle("R3 release core1");
      check("R10 idle cores not granted", grant, 4'b0000);
      done = '0;
      set_sig(2, 16'h0000, 16'h0001);
      set_sig(3, 16'h0000, 16'h0100);
      req = 4'b1100;
      cycle("R7 after core1");
      check("R7 core2 next in rotation", grant, 4'b0100);
      cycle("R6 second joins");
      check("R6 core3 joins core2", grant, 4'b1100);
      req = 4'b0000;
      done = 4'b1100;
      cycle("R3 release both");
      done = '0;

      // constrained random against the bench model
      for (int t = 0; t < 6000; t++) begin
         if (t % 256 == 0) par = 1'($urandom_range(0, 1));
         for (int i = 0; i < N; i++) begin
            if (!m_act[i]) begin
               req[i] = ($urandom_range(0, 1) == 1);
               rd[i] = W'($urandom & $urandom & $urandom);
               wr[i] = W'($urandom & $urandom & $urandom & $urandom);
            end else begin
               rd[i] = W'($urandom);
               wr[i] = W'($urandom);
            end
            done[i] = ($urandom_range(0, 3) == 0);
         end
         cycle("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule